// File: doc/BRIEF.md
# Memory-Mapped Pin Bank with Atomic Drive-Enable Set and Clear

This block is one bank of 32 general-purpose pins behind a small 32-bit register port. Software writes a drive-value register to choose the level each pin puts out. It writes a drive-enable register to decide which pins actually drive their pads. It reads a sampled-input register to see the pad levels. A separate sample-enable mask chooses which pins may show their pad level in the sampled-input register. Masked pins read as zero there.

Two write-only alias offsets change the drive-enable register one bit group at a time. Writing ones to the set alias turns those pins' drivers on. Writing ones to the clear alias turns them off. Pins written with zero keep their state. Because of this, separate agents can change different pins without a read-modify-write sequence. Pad inputs pass through a two-stage synchronizer before they reach the read path.

The register port takes one access per clock and has no back-pressure. A write takes effect at the rising edge where `bus_we` is high. A read is combinational: `bus_rdata` reflects `bus_addr` within the same cycle. The bus has no valid/ready stream, because every access finishes in a single cycle.

Top module: `pin_bank32`

## Requirements
- R1: A clock edge with `rst` high clears the drive-value, drive-enable and sample-enable registers to zero, so `pad_oe` and `pad_out` are 0 afterwards and all three registers read back as 0.
- R2: A write to byte offset 0x0C loads the drive-value register, which reads back at 0x0C. `pad_out` takes the new value on the clock edge of the write and not before.
- R3: A write to offset 0x10 loads the drive-enable register, which reads back at 0x10 and appears on `pad_oe` after the write edge. Only writes to 0x10, 0x70 or 0x74 can change `pad_oe`; bit n = 1 means pin n drives its pad.
- R4: A write to offset 0x70 sets every drive-enable bit whose written bit is 1, and leaves bits written 0 unchanged.
- R5: A write to offset 0x74 clears every drive-enable bit whose written bit is 1, and leaves bits written 0 unchanged.
- R6: The sample-enable mask is read/write at offset 0x58; bit n = 1 lets pin n's level through to the sampled-input register.
- R7: Reading offset 0x04 returns the synchronized pad level ANDed with the sample-enable mask. A pad change becomes visible after exactly two rising edges.
- R8: Reads of the alias offsets 0x70 and 0x74, and of any unmapped offset, return 0.
- R9: Writes to the read-only offset 0x04 or to unmapped offsets change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Raw pad levels, asynchronous to `clk` |
| pad_out | output | 32 | Level each pin drives when enabled |
| pad_oe | output | 32 | Per-pin driver enable, 1 = drive |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are stable around each rising edge and known whenever reset is low. They make no assumption about `pad_in` apart from it being sampled at the edge. The bench changes every bus input half a period away from the rising edge and holds it over the edge. It changes `pad_in` at the same point, so the count of synchronizer edges is exact. Reset is applied for whole cycles only, and writes are issued one per cycle with the strobe dropped between table entries.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int ADDR_W = 8;
  // Offsets decoded by software drivers; kept fixed.
  localparam logic [ADDR_W-1:0] OFF_SAMPLED = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DRIVE   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ENABLE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_SMASK   = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_EN_SET  = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 8'h74;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SAMPLED, SEL_DRIVE, SEL_ENABLE, SEL_SMASK, SEL_EN_SET, SEL_EN_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_SAMPLED: return SEL_SAMPLED;
      OFF_DRIVE:   return SEL_DRIVE;
      OFF_ENABLE:  return SEL_ENABLE;
      OFF_SMASK:   return SEL_SMASK;
      OFF_EN_SET:  return SEL_EN_SET;
      OFF_EN_CLR:  return SEL_EN_CLR;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= async_in;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
  import pin_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_sel_e        wr_sel,
  input  logic [NPIN-1:0] wr_data,
  output logic [NPIN-1:0] drive_q,
  output logic [NPIN-1:0] enable_q,
  output logic [NPIN-1:0] smask_q
);
  logic [NPIN-1:0] enable_d;

  always_comb begin
    enable_d = enable_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_ENABLE: enable_d = wr_data;
        SEL_EN_SET: enable_d = enable_q | wr_data;
        SEL_EN_CLR: enable_d = enable_q & ~wr_data;
        default:    enable_d = enable_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q  <= '0;
      enable_q <= '0;
      smask_q  <= '0;
    end else begin
      enable_q <= enable_d;
      if (wr_en && wr_sel == SEL_DRIVE) drive_q <= wr_data;
      if (wr_en && wr_sel == SEL_SMASK) smask_q <= wr_data;
    end
  end
endmodule

// File: rtl/pin_read_mux.sv
module pin_read_mux
  import pin_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  reg_sel_e        rd_sel,
  input  logic [NPIN-1:0] sampled,
  input  logic [NPIN-1:0] drive_q,
  input  logic [NPIN-1:0] enable_q,
  input  logic [NPIN-1:0] smask_q,
  output logic [NPIN-1:0] rd_data
);
  always_comb begin
    unique case (rd_sel)
      SEL_SAMPLED: rd_data = sampled & smask_q;
      SEL_DRIVE:   rd_data = drive_q;
      SEL_ENABLE:  rd_data = enable_q;
      SEL_SMASK:   rd_data = smask_q;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pin_bank32.sv
module pin_bank32
  import pin_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  reg_sel_e        sel;
  logic [NPIN-1:0] pad_sync;
  logic [NPIN-1:0] drive_q, enable_q, smask_q;

  assign sel = decode(bus_addr);

  pin_sync #(.WIDTH(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .async_in(pad_in), .sync_out(pad_sync)
  );

  pin_ctrl_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_sel(sel), .wr_data(bus_wdata),
    .drive_q(drive_q), .enable_q(enable_q), .smask_q(smask_q)
  );

  pin_read_mux #(.NPIN(NPIN)) u_rmux (
    .rd_sel(sel), .sampled(pad_sync), .drive_q(drive_q),
    .enable_q(enable_q), .smask_q(smask_q), .rd_data(bus_rdata)
  );

  assign pad_out = drive_q;
  assign pad_oe  = enable_q;
endmodule

// File: rtl/pin_bank32_chk.sv
module pin_bank32_chk
  import pin_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   smask
);
  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: after a reset edge the pads are released
  always @(negedge clk)
    if (rst_seen_q) p_reset_clear_r1: assert (pad_oe == '0 && pad_out == '0);

  p_drive_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_DRIVE) |=> pad_out == $past(bus_wdata));

  p_enable_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == OFF_ENABLE || bus_addr == OFF_EN_SET ||
                 bus_addr == OFF_EN_CLR)) |=> $stable(pad_oe));

  p_enable_set_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_EN_SET) |=> pad_oe == ($past(pad_oe) | $past(bus_wdata)));

  p_enable_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_EN_CLR) |=> pad_oe == ($past(pad_oe) & ~$past(bus_wdata)));

  p_sample_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFF_SAMPLED) |-> (bus_rdata & ~smask) == '0);

  p_alias_read_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFF_EN_SET || bus_addr == OFF_EN_CLR) |-> bus_rdata == '0);

  p_ignored_write_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == OFF_SAMPLED || bus_addr == 8'h20)) |=> $stable(pad_out));
endmodule

bind pin_bank32 pin_bank32_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .smask(smask_q)
);

// File: tb/test_pin_bank32.sv
`timescale 1ns/1ps
module test_pin_bank32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_bank32 i_pin_bank32 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {write, req, addr, data}; a read entry holds the expected data
  localparam int NV = 20;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 4'd2, 8'h0C, 32'hA5A5_0F0F},  // R2
    {1'b0, 4'd2, 8'h0C, 32'hA5A5_0F0F},  // R2
    {1'b1, 4'd3, 8'h10, 32'h0000_FFFF},  // R3
    {1'b0, 4'd3, 8'h10, 32'h0000_FFFF},  // R3
    {1'b1, 4'd4, 8'h70, 32'h00FF_0000},  // R4
    {1'b0, 4'd4, 8'h10, 32'h00FF_FFFF},  // R4
    {1'b1, 4'd4, 8'h70, 32'h0000_0000},  // R4 zeros keep state
    {1'b0, 4'd4, 8'h10, 32'h00FF_FFFF},  // R4
    {1'b1, 4'd5, 8'h74, 32'h0000_00F0},  // R5
    {1'b0, 4'd5, 8'h10, 32'h00FF_FF0F},  // R5
    {1'b1, 4'd6, 8'h58, 32'h1234_5678},  // R6
    {1'b0, 4'd6, 8'h58, 32'h1234_5678},  // R6
    {1'b0, 4'd8, 8'h70, 32'h0000_0000},  // R8
    {1'b0, 4'd8, 8'h74, 32'h0000_0000},  // R8
    {1'b0, 4'd8, 8'h08, 32'h0000_0000},  // R8
    {1'b1, 4'd9, 8'h04, 32'hFFFF_FFFF},  // R9
    {1'b1, 4'd9, 8'h20, 32'hFFFF_FFFF},  // R9
    {1'b0, 4'd9, 8'h0C, 32'hA5A5_0F0F},  // R9
    {1'b0, 4'd9, 8'h10, 32'h00FF_FF0F},  // R9
    {1'b0, 4'd9, 8'h58, 32'h1234_5678}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", pad_oe, 32'h0);
    check("R1", pad_out, 32'h0);
    rd("R1", 8'h0C, 32'h0);
    rd("R1", 8'h10, 32'h0);
    rd("R1", 8'h58, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][39:32], VEC[i][31:0]);
      else rd($sformatf("R%0d", VEC[i][43:40]), VEC[i][39:32], VEC[i][31:0]);
    end
    check("R2", pad_out, 32'hA5A5_0F0F);
    check("R3", pad_oe, 32'h00FF_FF0F);

    // R2 latency: pad_out unchanged before the write edge
    @(negedge clk);
    bus_addr = 8'h0C; bus_we = 1'b1; bus_wdata = 32'h0F0F_1234;
    #0.5 check("R2", pad_out, 32'hA5A5_0F0F);
    @(negedge clk);
    bus_we = 1'b0;
    check("R2", pad_out, 32'h0F0F_1234);

    // R7 two-edge synchronizer, masked with 0x12345678
    @(negedge clk);
    pad_in = 32'hFFFF_0000;
    rd("R7", 8'h04, 32'h0);
    @(negedge clk);
    rd("R7", 8'h04, 32'h0);
    @(negedge clk);
    rd("R7", 8'h04, 32'h1234_0000);
    wr(8'h58, 32'hFFFF_FFFF);
    rd("R7", 8'h04, 32'hFFFF_0000);

    // R1 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", pad_oe, 32'h0);
    check("R1", pad_out, 32'h0);
    rd("R1", 8'h58, 32'h0);
    rd("R7", 8'h04, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule